// File: doc/BRIEF.md
# SRAM Power-Down Handshake Sequencer

This block powers a domain's local SRAM up and down. A one-cycle command carries the direction: power up or power down. The block drives a multi-bit power-down request field toward the SRAM macros. It then waits for their acknowledge field, seen through a synchronizer, to reach the expected value. When the domain has isolation, the block also drives a clock-isolation control and an active-low interrupt-isolation control. It changes these two controls one after the other, with a fixed settling gap between them.

Two static configuration inputs shape each run. The first reverses the polarity of the request field, and with it the acknowledge value that the block waits for. The second says whether the isolation pair is present. The block samples the acknowledge at a fixed interval and gives up after a bounded number of samples. It reports the result as a one-cycle done pulse or a one-cycle error pulse. The poll interval, the settling gap and the timeout are parameters counted in clock cycles.

Top module: `sram_pdn_seq`

## Requirements
- R1: After reset the request field is all ones, clock isolation is 1, interrupt isolation (active low) is 0, and busy, done and error are 0.
- R2: A power-up command with normal polarity (inv=0) drives every request bit to 0 in the cycle the command is accepted. The block then waits until the synchronized acknowledge is all zeros.
- R3: A power-down command with normal polarity drives every request bit to 1 and waits until the synchronized acknowledge is all ones.
- R4: With inv=1 the request value and the expected acknowledge are swapped. Power-up drives all ones and waits for all ones. Power-down drives all zeros and waits for all zeros.
- R5: On power-up with isolation (iso=1), interrupt isolation rises only after the acknowledge matches. Clock isolation falls exactly SETTLE_CYC cycles later, and done pulses in that same cycle.
- R6: On power-down with iso=1, clock isolation rises in the cycle the command is accepted. Exactly SETTLE_CYC cycles later, interrupt isolation falls and the request field changes, both in the same cycle.
- R7: With iso=0 neither isolation output changes during a command.
- R8: The acknowledge is tested once every POLL_CYC cycles. If it has not matched after TIMEOUT_POLLS tests, the error pulse appears exactly POLL_CYC*TIMEOUT_POLLS cycles after the command is accepted. On a power-up timeout both isolation outputs keep their values.
- R9: A command that arrives while busy is high is ignored.
- R10: Done and error each last exactly one cycle, are never high together, and appear in the cycle busy returns to 0. All outputs then hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_on | input | 1 | Command direction: 1 power up, 0 power down |
| cfg_inv | input | 1 | Request/acknowledge polarity swap |
| cfg_iso | input | 1 | Isolation pair present |
| ack_i | input | ACK_W | Acknowledge bus from the SRAM macros (asynchronous) |
| pdn_req_o | output | ACK_W | Power-down request field |
| clk_iso_o | output | 1 | Clock isolation, 1 = isolated |
| int_iso_n_o | output | 1 | Interrupt isolation, active low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle timeout pulse |

## Verification
A delayed acknowledge model follows the request field. Each of the four combinations of direction and polarity is run against it, so a swapped request value or a swapped expected acknowledge shows up in the field the block settles on. Runs with isolation record the cycle in which each isolation output and the request field change. This separates the power-up ordering from the power-down ordering and measures the settling gap exactly. Runs without isolation show that the pair stays untouched. A stuck acknowledge checks the exact timeout cycle and that the isolation pair keeps its values. A command issued in the middle of a run checks that it is dropped.

// File: rtl/sram_pdn_pkg.sv
package sram_pdn_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GAP  = 2'd1,
      ST_POLL = 2'd2
   } seq_state_t;

   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/sram_pdn_sync.sv
module sram_pdn_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("sram_pdn_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d_i;
            else             stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sram_pdn_cnt.sv
module sram_pdn_cnt #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic hit_o
);
   localparam int CW = sram_pdn_pkg::cnt_width(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (LIMIT < 1) begin : g_bad
         $error("sram_pdn_cnt LIMIT must be at least 1");
      end
   endgenerate

   assign hit_o = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (inc_i) cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/sram_pdn_seq.sv
module sram_pdn_seq #(
   parameter int ACK_W         = 4,
   parameter int POLL_CYC      = 2500,
   parameter int SETTLE_CYC    = 250,
   parameter int TIMEOUT_POLLS = 100000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_on,
   input  logic             cfg_inv,
   input  logic             cfg_iso,
   input  logic [ACK_W-1:0] ack_i,
   output logic [ACK_W-1:0] pdn_req_o,
   output logic             clk_iso_o,
   output logic             int_iso_n_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);
   import sram_pdn_pkg::*;

   generate
      if (ACK_W < 1) begin : g_bad_w
         $error("ACK_W must be at least 1");
      end
   endgenerate

   seq_state_t       state_q;
   logic             dir_on_q, inv_q, iso_q;
   logic [ACK_W-1:0] ack_s;
   logic             req_bit;
   logic             accept, ack_match;
   logic             settle_hit, poll_hit, tries_hit;
   logic             poll_tick, poll_miss;

   sram_pdn_sync #(.WIDTH(ACK_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ack_i), .q_o(ack_s)
   );

   sram_pdn_cnt #(.LIMIT(SETTLE_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n),
      .clr_i(state_q != ST_GAP), .inc_i(state_q == ST_GAP), .hit_o(settle_hit)
   );

   sram_pdn_cnt #(.LIMIT(POLL_CYC)) u_poll (
      .clk(clk), .rst_n(rst_n),
      .clr_i(state_q != ST_POLL), .inc_i(state_q == ST_POLL), .hit_o(poll_hit)
   );

   sram_pdn_cnt #(.LIMIT(TIMEOUT_POLLS)) u_tries (
      .clk(clk), .rst_n(rst_n),
      .clr_i(state_q != ST_POLL), .inc_i(poll_miss), .hit_o(tries_hit)
   );

   // request level: 0 for power-up, 1 for power-down, swapped by polarity
   assign req_bit   = ~dir_on_q ^ inv_q;
   assign accept    = (state_q == ST_IDLE) && cmd_valid;
   assign ack_match = (ack_s == {ACK_W{req_bit}});
   assign poll_tick = (state_q == ST_POLL) && poll_hit;
   assign poll_miss = poll_tick && !ack_match;
   assign busy_o    = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         dir_on_q    <= 1'b0;
         inv_q       <= 1'b0;
         iso_q       <= 1'b0;
         pdn_req_o   <= '1;
         clk_iso_o   <= 1'b1;
         int_iso_n_o <= 1'b0;
         done_o      <= 1'b0;
         err_o       <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  dir_on_q <= cmd_on;
                  inv_q    <= cfg_inv;
                  iso_q    <= cfg_iso;
                  if (!cmd_on && cfg_iso) begin
                     clk_iso_o <= 1'b1;
                     state_q   <= ST_GAP;
                  end else begin
                     pdn_req_o <= {ACK_W{~cmd_on ^ cfg_inv}};
                     state_q   <= ST_POLL;
                  end
               end
            end
            ST_GAP: begin
               if (settle_hit) begin
                  if (dir_on_q) begin
                     clk_iso_o <= 1'b0;
                     done_o    <= 1'b1;
                     state_q   <= ST_IDLE;
                  end else begin
                     int_iso_n_o <= 1'b0;
                     pdn_req_o   <= {ACK_W{req_bit}};
                     state_q     <= ST_POLL;
                  end
               end
            end
            ST_POLL: begin
               if (poll_tick) begin
                  if (ack_match) begin
                     if (dir_on_q && iso_q) begin
                        int_iso_n_o <= 1'b1;
                        state_q     <= ST_GAP;
                     end else begin
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                     end
                  end else if (tries_hit) begin
                     err_o   <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   logic unused_accept;
   assign unused_accept = accept;
endmodule

// File: rtl/sram_pdn_seq_chk.sv
module sram_pdn_seq_chk #(
   parameter int ACK_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [ACK_W-1:0] pdn_req_o,
   input logic             clk_iso_o,
   input logic             int_iso_n_o,
   input logic             busy_o,
   input logic             done_o,
   input logic             err_o
);
   assert_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);

   assert_end_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || err_o) |-> !busy_o);

   assert_up_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_iso_o) |-> int_iso_n_o);

   assert_down_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_iso_n_o) |-> clk_iso_o);

   assert_req_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pdn_req_o) |-> ($past(busy_o) || $past(cmd_valid)));

   assert_err_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(busy_o));
endmodule

bind sram_pdn_seq sram_pdn_seq_chk #(.ACK_W(ACK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .pdn_req_o(pdn_req_o),
   .clk_iso_o(clk_iso_o), .int_iso_n_o(int_iso_n_o), .busy_o(busy_o),
   .done_o(done_o), .err_o(err_o)
);

// File: tb/sram_pdn_seq_bench.sv
module sram_pdn_seq_bench;
   localparam int W  = 4;
   localparam int PC = 4;
   localparam int SC = 3;
   localparam int TO = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0, cmd_on = 1'b0, cfg_inv = 1'b0, cfg_iso = 1'b1;
   logic [W-1:0] ack = '1;
   logic [W-1:0] pdn_req;
   logic         clk_iso, int_iso_n, busy, done, err;

   int cyc = 0, errors = 0, checks = 0;
   int t0, t_req, t_clk, t_int, t_end;
   bit stuck = 1'b0, got_err = 1'b0;
   logic [W-1:0] d1 = '1, d2 = '1, p_req = '1;
   logic p_clk = 1'b1, p_int = 1'b0;

   always #2 clk = ~clk;

   sram_pdn_seq #(.ACK_W(W), .POLL_CYC(PC), .SETTLE_CYC(SC), .TIMEOUT_POLLS(TO)) u_sram_pdn_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_on(cmd_on),
      .cfg_inv(cfg_inv), .cfg_iso(cfg_iso), .ack_i(ack), .pdn_req_o(pdn_req),
      .clk_iso_o(clk_iso), .int_iso_n_o(int_iso_n), .busy_o(busy),
      .done_o(done), .err_o(err)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // SRAM model: acknowledge follows the request two cycles later
   always @(negedge clk) begin
      d1 <= pdn_req;
      d2 <= d1;
      if (!stuck) ack <= d2;
   end

   // change monitor
   always @(negedge clk) begin
      if (pdn_req !== p_req)   t_req = cyc;
      if (clk_iso !== p_clk)   t_clk = cyc;
      if (int_iso_n !== p_int) t_int = cyc;
      p_req = pdn_req; p_clk = clk_iso; p_int = int_iso_n;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic issue(input logic on);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_on = on; t0 = cyc + 1;
      @(negedge clk);
      #1 cmd_valid = 1'b0;
   endtask

   task automatic wait_end();
      got_err = 1'b0;
      for (int i = 0; i < 400; i++) begin
         if (done || err) break;
         @(negedge clk); #1;
      end
      got_err = err;
      t_end = cyc;
      chk("R10 end pulse seen", int'(done || err), 1);
      chk("R10 busy low at end", int'(busy), 0);
      @(negedge clk); #1;
      chk("R10 pulse one cycle", int'(done || err), 0);
   endtask

   task automatic t_reset();
      chk("R1 req", int'(pdn_req), 15);
      chk("R1 clk_iso", int'(clk_iso), 1);
      chk("R1 int_iso_n", int'(int_iso_n), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 done/err", int'(done || err), 0);
   endtask

   task automatic t_up_normal_iso();
      cfg_inv = 0; cfg_iso = 1;
      issue(1'b1); wait_end();
      chk("R2 req zero", int'(pdn_req), 0);
      chk("R2 req at accept", t_req, t0);
      chk("R2 success", int'(got_err), 0);
      chk("R5 int_iso_n high", int'(int_iso_n), 1);
      chk("R5 clk_iso low", int'(clk_iso), 0);
      chk("R5 int after req", int'(t_int > t_req), 1);
      chk("R5 settle gap", t_clk - t_int, SC);
      chk("R5 done with clk_iso", t_end, t_clk);
   endtask

   task automatic t_down_busy_ignore();
      int ts;
      cfg_inv = 0; cfg_iso = 1;
      issue(1'b0); ts = t0;
      @(negedge clk);
      issue(1'b1);
      wait_end();
      chk("R3 req ones", int'(pdn_req), 15);
      chk("R6 clk_iso at accept", t_clk, ts);
      chk("R6 int_iso_n gap", t_int, ts + SC);
      chk("R6 req with int_iso", t_req, ts + SC);
      chk("R6 iso engaged", int'({clk_iso, int_iso_n}), 2);
      repeat (20) @(negedge clk);
      chk("R9 busy after ignored cmd", int'(busy), 0);
      chk("R9 req unchanged", int'(pdn_req), 15);
   endtask

   task automatic t_inverted();
      cfg_inv = 1; cfg_iso = 1;
      issue(1'b1); wait_end();
      chk("R4 up inv req ones", int'(pdn_req), 15);
      chk("R4 up inv success", int'(got_err), 0);
      chk("R4 up inv iso released", int'({clk_iso, int_iso_n}), 1);
      issue(1'b0); wait_end();
      chk("R4 down inv req zero", int'(pdn_req), 0);
      chk("R4 down inv success", int'(got_err), 0);
      chk("R4 down inv iso engaged", int'({clk_iso, int_iso_n}), 2);
   endtask

   task automatic t_no_iso();
      cfg_inv = 0; cfg_iso = 1;
      issue(1'b1); wait_end();
      cfg_iso = 0;
      issue(1'b0); wait_end();
      chk("R7 down req ones", int'(pdn_req), 15);
      chk("R7 down iso untouched", int'({clk_iso, int_iso_n}), 1);
      issue(1'b1); wait_end();
      chk("R7 up req zero", int'(pdn_req), 0);
      chk("R7 up iso untouched", int'({clk_iso, int_iso_n}), 1);
      chk("R8 poll grid", (t_end - t0) % PC, 0);
   endtask

   task automatic t_timeout();
      cfg_inv = 0; cfg_iso = 1;
      issue(1'b0); wait_end();
      repeat (4) @(negedge clk);
      stuck = 1'b1;
      issue(1'b1); wait_end();
      chk("R8 error raised", int'(got_err), 1);
      chk("R8 error cycle", t_end, t0 + PC * TO);
      chk("R8 iso kept", int'({clk_iso, int_iso_n}), 2);
      stuck = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_up_normal_iso();
      t_down_busy_ignore();
      t_inverted();
      t_no_iso();
      t_timeout();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #100000;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule